// File: doc/BRIEF.md
# Scaled 8-Point FFT Engine

This block computes an eight-point radix-2 decimation-in-time Fourier transform on real 16-bit Q15 samples. A single-cycle `start` pulse arms it. It then takes eight samples, one on each cycle that `in_valid` is high, and may wait any number of idle cycles between them. Each sample goes into an internal complex store at its bit-reversed position, with a zero imaginary part.

Once the eighth sample has arrived, the engine runs three passes. The first two passes each cover one group of four points: they apply the first two butterfly stages together and divide by four. The third pass does the final stage on all four pairs at once and divides by two. The result is the DFT divided by eight, computed with sign-extended two's complement arithmetic and no saturation. The engine then streams sixteen words, one per cycle, with real and imaginary parts interleaved in natural bin order. It raises `done` for one cycle and returns to idle.

The only multiplier constant is the Q15 value of cos(pi/4). The -j rotation needs no multiplier.

Top module: `fft8_scaled`

## Requirements
- R1: After reset, `busy`, `out_valid` and `done` are all low.
- R2: A `start` pulse while idle raises `busy` on the next cycle. The engine then accepts exactly eight samples, one per cycle with `in_valid` high. Cycles with `in_valid` low between samples are skipped.
- R3: The transform of eight equal samples of value v gives bin 0 real part v and zero in every other word. A lone sample v at index 0 gives real part floor(v/4)/2 (rounded down) in every bin and zero imaginary parts.
- R4: Sample n is stored at position rev(n), where rev reverses the three index bits. The first pass works on positions {0..3} and then on {4..7}, as a, b, c, d, with sa=a+b, da=a-b, sc=c+d, dc=c-d. It writes floor((sa+sc)/4), floor((da-j·dc)/4), floor((sa-sc)/4) and floor((da+j·dc)/4) to the four positions in that order.
- R5: The final pass pairs position k with k+4 (k=0..3), with P at k and Q at k+4. The rotated value T is Q for k=0, (QI, -QR) for k=2, (m(QR+QI), m(QI-QR)) for k=1, and (m(QI-QR), -m(QR+QI)) for k=3. Position k receives floor((P+T)/2) and position k+4 receives floor((P-T)/2). Each part keeps its low 16 bits, with no saturation.
- R6: m(s) = floor(s·23170 / 32768), where 23170 is 0x5A82. This truncates the product's fraction bits.
- R7: The first output word appears on `out_valid` after the third rising edge that follows acceptance of the eighth sample. `out_valid` then stays high for sixteen consecutive cycles. Word 2k is the real part of bin k and word 2k+1 is its imaginary part.
- R8: `done` is high for exactly one cycle, the cycle right after the last output word. `busy` is low on the following cycle.
- R9: `start` pulses while busy, and `in_valid` outside the sample-loading phase, have no effect on the outputs or on when the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a transform when idle |
| in_valid | input | 1 | Qualifies `in_data` during sample loading |
| in_data | input | 16 | Real Q15 input sample |
| busy | output | 1 | High from accepted start through the `done` cycle |
| out_valid | output | 1 | Qualifies `out_data` |
| out_data | output | 16 | Interleaved real/imaginary result word |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land on the same cycle as a running transform. One is a `start` pulse that arrives while the sixteen result words are streaming. The other is `in_valid` held high with junk data for several cycles after the eighth sample, while the butterfly passes are writing the store. The bench provokes both in one run. It judges them at the ports: every streamed word must still match the model of the requirement formulas, `done` must pulse at its usual cycle, and `busy` must be low one cycle later, which shows that no new transform began.

// File: rtl/fft8_scaled.sv
module fft8_scaled (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        busy,
  output logic        out_valid,
  output logic [15:0] out_data,
  output logic        done
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_FUSE0, S_FUSE1, S_FINAL, S_OUT, S_DONE} state_t;

  localparam logic signed [18:0] TWID = 19'sd23170;

  state_t      state;
  logic [3:0]  cnt;
  logic [15:0] re [8];
  logic [15:0] im [8];

  function automatic logic [2:0] rev3(input logic [2:0] v);
    return {v[0], v[1], v[2]};
  endfunction

  function automatic logic signed [18:0] sx(input logic [15:0] v);
    return {{3{v[15]}}, v};
  endfunction

  function automatic logic signed [18:0] twmul(input logic signed [18:0] s);
    logic signed [37:0] p;
    p = 38'(s) * 38'(TWID);
    return 19'(p >>> 15);
  endfunction

  assign busy      = (state != S_IDLE);
  assign out_valid = (state == S_OUT);
  assign done      = (state == S_DONE);
  assign out_data  = cnt[0] ? im[cnt[3:1]] : re[cnt[3:1]];

  // Fused first and second stages on one four-point group
  logic [2:0] gb;
  assign gb = (state == S_FUSE1) ? 3'd4 : 3'd0;

  logic signed [18:0] sar, sai, dar, dai, scr, sci, dcr, dci;
  logic [15:0] fr [4];
  logic [15:0] fi [4];

  always_comb begin
    sar = sx(re[gb])      + sx(re[gb + 3'd1]);
    sai = sx(im[gb])      + sx(im[gb + 3'd1]);
    dar = sx(re[gb])      - sx(re[gb + 3'd1]);
    dai = sx(im[gb])      - sx(im[gb + 3'd1]);
    scr = sx(re[gb + 3'd2]) + sx(re[gb + 3'd3]);
    sci = sx(im[gb + 3'd2]) + sx(im[gb + 3'd3]);
    dcr = sx(re[gb + 3'd2]) - sx(re[gb + 3'd3]);
    dci = sx(im[gb + 3'd2]) - sx(im[gb + 3'd3]);
    fr[0] = 16'((sar + scr) >>> 2);
    fi[0] = 16'((sai + sci) >>> 2);
    fr[1] = 16'((dar + dci) >>> 2);
    fi[1] = 16'((dai - dcr) >>> 2);
    fr[2] = 16'((sar - scr) >>> 2);
    fi[2] = 16'((sai - sci) >>> 2);
    fr[3] = 16'((dar - dci) >>> 2);
    fi[3] = 16'((dai + dcr) >>> 2);
  end

  // Final stage: four butterflies with twiddles W^0..W^3
  logic [15:0] npr [4];
  logic [15:0] npi [4];
  logic [15:0] nqr [4];
  logic [15:0] nqi [4];

  for (genvar k = 0; k < 4; k++) begin : g_bfly
    logic signed [18:0] pr, pi, qr, qi, tr, ti;
    assign pr = sx(re[k]);
    assign pi = sx(im[k]);
    assign qr = sx(re[k+4]);
    assign qi = sx(im[k+4]);
    if (k == 0) begin : g_w0
      assign tr = qr;
      assign ti = qi;
    end else if (k == 1) begin : g_w1
      assign tr = twmul(qr + qi);
      assign ti = twmul(qi - qr);
    end else if (k == 2) begin : g_w2
      assign tr = qi;
      assign ti = -qr;
    end else begin : g_w3
      assign tr = twmul(qi - qr);
      assign ti = -twmul(qr + qi);
    end
    assign npr[k] = 16'((pr + tr) >>> 1);
    assign npi[k] = 16'((pi + ti) >>> 1);
    assign nqr[k] = 16'((pr - tr) >>> 1);
    assign nqi[k] = 16'((pi - ti) >>> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      for (int k = 0; k < 8; k++) begin
        re[k] <= '0;
        im[k] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_LOAD;
          cnt   <= '0;
        end
        S_LOAD: if (in_valid) begin
          re[rev3(cnt[2:0])] <= in_data;
          im[rev3(cnt[2:0])] <= '0;
          cnt <= cnt + 4'd1;
          if (cnt[2:0] == 3'd7) state <= S_FUSE0;
        end
        S_FUSE0, S_FUSE1: begin
          for (int k = 0; k < 4; k++) begin
            re[gb + 3'(k)] <= fr[k];
            im[gb + 3'(k)] <= fi[k];
          end
          state <= (state == S_FUSE0) ? S_FUSE1 : S_FINAL;
        end
        S_FINAL: begin
          for (int k = 0; k < 4; k++) begin
            re[k]   <= npr[k];
            im[k]   <= npi[k];
            re[k+4] <= nqr[k];
            im[k+4] <= nqi[k];
          end
          cnt   <= '0;
          state <= S_OUT;
        end
        S_OUT: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd15) state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !out_valid && !done));

  assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_load_waits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && !in_valid) |=> (state == S_LOAD && $stable(cnt)));

  assert_outvalid_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_follows_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> done);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && start && cnt != 4'd15) |=> out_valid);

endmodule

// File: tb/fft8_scaled_tb.sv
module fft8_scaled_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic busy, out_valid, done;
  logic [15:0] out_data;

  int n_checks = 0;
  int n_fail = 0;
  int seed = 12345;

  always #(CLK_PERIOD/2) clk = ~clk;

  fft8_scaled dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrap16(input int v);
    return ((v + 32768) & 65535) - 32768;
  endfunction

  function automatic int m_tw(input int s);
    return (s * 23170) >>> 15;
  endfunction

  function automatic int rv(input int n);
    return ((n & 1) << 2) | (n & 2) | ((n >> 2) & 1);
  endfunction

  function automatic void ref_fft(input int x[8], output int y[16]);
    int r[8];
    int q[8];
    int tr, ti, p0r, p0i;
    for (int n = 0; n < 8; n++) begin r[rv(n)] = x[n]; q[rv(n)] = 0; end
    for (int g = 0; g < 8; g += 4) begin
      int sar, sai, dar, dai, scr, sci, dcr, dci;
      sar = r[g] + r[g+1];   sai = q[g] + q[g+1];
      dar = r[g] - r[g+1];   dai = q[g] - q[g+1];
      scr = r[g+2] + r[g+3]; sci = q[g+2] + q[g+3];
      dcr = r[g+2] - r[g+3]; dci = q[g+2] - q[g+3];
      r[g]   = (sar + scr) >>> 2; q[g]   = (sai + sci) >>> 2;
      r[g+1] = (dar + dci) >>> 2; q[g+1] = (dai - dcr) >>> 2;
      r[g+2] = (sar - scr) >>> 2; q[g+2] = (sai - sci) >>> 2;
      r[g+3] = (dar - dci) >>> 2; q[g+3] = (dai + dcr) >>> 2;
    end
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: begin tr = r[4]; ti = q[4]; end
        1: begin tr = m_tw(r[5] + q[5]); ti = m_tw(q[5] - r[5]); end
        2: begin tr = q[6]; ti = -r[6]; end
        default: begin tr = m_tw(q[7] - r[7]); ti = -m_tw(r[7] + q[7]); end
      endcase
      p0r = r[k]; p0i = q[k];
      r[k]   = wrap16((p0r + tr) >>> 1); q[k]   = wrap16((p0i + ti) >>> 1);
      r[k+4] = wrap16((p0r - tr) >>> 1); q[k+4] = wrap16((p0i - ti) >>> 1);
    end
    for (int k = 0; k < 8; k++) begin y[2*k] = r[k]; y[2*k+1] = q[k]; end
  endfunction

  task automatic run_fft(input int x[8], input int gap, input bit extra, input bit poke,
                         output int got[16]);
    int lat;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2", "busy after start", int'(busy), 1);
    for (int n = 0; n < 8; n++) begin
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
      in_valid = 1'b1;
      in_data  = 16'(x[n]);
      @(negedge clk);
    end
    lat = 0;
    while (!out_valid && lat < 50) begin
      if (extra && lat < 3) begin in_valid = 1'b1; in_data = 16'h7FFF; start = 1'b1; end
      else begin in_valid = 1'b0; start = 1'b0; end
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0; start = 1'b0;
    check("R7", "output latency", lat, 3);
    for (int k = 0; k < 16; k++) begin
      check("R7", "out_valid in stream", int'(out_valid), 1);
      got[k] = int'($signed(out_data));
      start = (poke && (k == 5 || k == 15)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R8", "done after stream", int'(done), 1);
    check("R8", "out_valid low at done", int'(out_valid), 0);
    @(negedge clk);
    check("R8", "done single cycle", int'(done), 0);
    check("R9", "busy low after done", int'(busy), 0);
  endtask

  task automatic compare(input string req, input int got[16], input int exp[16]);
    for (int k = 0; k < 16; k++) check(req, $sformatf("word %0d", k), got[k], exp[k]);
  endtask

  task automatic t_reset();
    check("R1", "busy at reset", int'(busy), 0);
    check("R1", "out_valid at reset", int'(out_valid), 0);
    check("R1", "done at reset", int'(done), 0);
    in_valid = 1'b1; in_data = 16'h1234;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    check("R9", "in_valid while idle leaves busy low", int'(busy), 0);
  endtask

  task automatic t_dc();
    int x[8]; int got[16]; int exp[16];
    for (int n = 0; n < 8; n++) x[n] = 4096;
    for (int k = 0; k < 16; k++) exp[k] = 0;
    exp[0] = 4096;
    run_fft(x, 0, 1'b0, 1'b0, got);
    compare("R3 dc", got, exp);
  endtask

  task automatic t_impulse();
    int x[8]; int got[16]; int exp[16];
    for (int n = 0; n < 8; n++) x[n] = 0;
    x[0] = 8000;
    for (int k = 0; k < 16; k++) exp[k] = (k % 2 == 0) ? 1000 : 0;
    run_fft(x, 1, 1'b0, 1'b0, got);
    compare("R3 impulse", got, exp);
  endtask

  task automatic t_twiddle();
    int x[8]; int got[16]; int exp[16];
    for (int n = 0; n < 8; n++) x[n] = 0;
    x[1] = 16384; x[3] = -12000;
    ref_fft(x, exp);
    run_fft(x, 0, 1'b0, 1'b0, got);
    compare("R6 twiddle", got, exp);
  endtask

  task automatic t_random();
    int x[8]; int got[16]; int exp[16];
    for (int r = 0; r < 3; r++) begin
      for (int n = 0; n < 8; n++) begin
        seed = seed * 1103515245 + 12345;
        x[n] = ((seed >>> 8) & 65535) - 32768;
      end
      ref_fft(x, exp);
      run_fft(x, r, 1'b0, 1'b0, got);
      compare(r == 0 ? "R4 random" : "R2 gapped", got, exp);
    end
  endtask

  task automatic t_extreme();
    int x[8]; int got[16]; int exp[16];
    for (int n = 0; n < 8; n++) x[n] = -32768;
    ref_fft(x, exp);
    run_fft(x, 0, 1'b0, 1'b0, got);
    compare("R5 full scale", got, exp);
    for (int n = 0; n < 8; n++) x[n] = (n % 2 == 0) ? 32767 : -32768;
    ref_fft(x, exp);
    run_fft(x, 0, 1'b0, 1'b0, got);
    compare("R5 alternating", got, exp);
  endtask

  task automatic t_overlap();
    int x[8]; int got[16]; int exp[16];
    for (int n = 0; n < 8; n++) x[n] = 3000 * n - 9000;
    ref_fft(x, exp);
    run_fft(x, 0, 1'b1, 1'b1, got);
    compare("R9 overlap", got, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dc();
    t_impulse();
    t_twiddle();
    t_random();
    t_extreme();
    t_overlap();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule